// File: doc/BRIEF.md
# Externally Clocked Timer Counter

This block is a 16-bit up-counter that runs on the system clock but can be made to advance only on qualified edges of an asynchronous pin. The pin is brought into the clock domain by a two-stage synchronizer. It then goes through an optional inversion and a glitch filter that needs a programmable number of matching samples. A rising-edge detector and an edge prescaler (/1, /2, /4, /8) follow. The resulting pulses, or the rising edges of one of three on-chip trigger lines, or simply every clock, feed a 16-bit count divider and a counter that wraps at a programmable period and sets a sticky overflow flag.

There are two routes to the pin-driven count. In the first, a 3-bit slave-mode field is set to 3'b111 and a 2-bit trigger selector chooses the source. In the second, a single direct-enable bit is set, and this bit overrides the slave-mode settings. Software configures the block through a write-only parallel port with four word addresses. The count and the flag are plain outputs.

Top module: `ext_clk_timer`

## Requirements
- R1: After reset, count is 0, ovf_flag is 0, and all control fields, the divider and the period are 0 (timer stopped).
- R2: With the direct-enable bit 0 and the slave-mode field not 3'b111, the running counter (divider 0) advances by one every clock.
- R3: While the run bit (control bit 0) is 0, the count holds its value.
- R4: On a count step taken while count equals the period (address 2), the count becomes 0 and ovf_flag is set. With period 0x32 the count goes ...0x31, 0x32, 0, 1...
- R5: ovf_flag stays set until a write to address 3 with bit 0 equal to 0. A write there with bit 0 equal to 1 leaves it set.
- R6: With the direct-enable bit (control bit 1) set, each rising edge of ext_pin gives one count. With filter 0 and divider 0, the count changes on the third rising clock edge after the first clock edge that samples the new pin level.
- R7: With the polarity bit (control bit 7) set, falling edges of ext_pin count and rising edges do not.
- R8: The edge-division field (control bits 9:8) passes one count for every 1, 2, 4 or 8 qualified pin edges for codes 00, 01, 10 and 11.
- R9: The filter field (control bits 13:10) value F requires N = F/2 + 1 (integer division) consecutive matching samples before the filtered level changes. A pin pulse shorter than N clocks is ignored; a pulse of exactly N clocks is counted.
- R10: With the slave-mode field (control bits 4:2) equal to 3'b111 and direct enable off, trigger-select code (control bits 6:5) 3 counts qualified pin edges. Codes 0 to 2 count rising edges of int_trig[code] and ignore the pin.
- R11: When direct enable and slave mode 3'b111 are both set, the qualified pin edges are the count source and the trigger lines are ignored.
- R12: A divider value D (address 1) gives one count per D+1 source events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address: 0 control, 1 divider, 2 period, 3 flag clear |
| wr_data | input | 16 | Write data |
| ext_pin | input | 1 | Asynchronous external count signal |
| int_trig | input | 3 | On-chip trigger lines, synchronous to clk |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench attacks the filter boundary, with pulses one clock shorter than and exactly equal to the required run length. A filter that is off by one would either count the short glitch or drop the legal pulse. It also pins down the exact cycle of the first increment after a pin edge, the wrap at the period value, and the flag-clear write that carries a 1, so that an extra register stage, a wrap one step late or a clear on any write each turn up as a wrong count or flag. Combined configurations then check that the direct enable overrides the trigger selector, and that a selector code of 0 to 2 ignores the pin. An edge prescaler that is left on its idle state also fails those checks.

// File: rtl/ect_pkg.sv
package ect_pkg;
  // Control word layout, bit 0 first from the right.
  typedef struct packed {
    logic [3:0] filt;    // 13:10 filter strength
    logic [1:0] ediv;    // 9:8   edge division code
    logic       pol;     // 7     invert pin
    logic [1:0] tsel;    // 6:5   trigger source
    logic [2:0] smode;   // 4:2   slave mode
    logic       mode_b;  // 1     direct external enable
    logic       run;     // 0     timer enable
  } ect_ctrl_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DIV  = 2'd1;
  localparam logic [1:0] A_PER  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam logic [2:0] SMODE_EXT = 3'b111;
endpackage

// File: rtl/ect_regs.sv
module ect_regs
  import ect_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ect_ctrl_t         ctrl,
  output logic [DATA_W-1:0] div_val,
  output logic [DATA_W-1:0] period,
  output logic              ovf_clr
);
  localparam int CTRL_W = $bits(ect_ctrl_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      div_val <= '0;
      period  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl    <= ect_ctrl_t'(wr_data[CTRL_W-1:0]);
        A_DIV:   div_val <= wr_data;
        A_PER:   period  <= wr_data;
        default: ;
      endcase
    end
  end

  // Clearing the flag needs a 0 in bit 0; a 1 is harmless.
  assign ovf_clr = wr_en && (wr_addr == A_STAT) && !wr_data[0];
endmodule

// File: rtl/ect_ext_path.sv
module ect_ext_path #(
  parameter int SYNC_N = 2,
  parameter int FILT_W = 4,
  parameter int EDIV_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              pin,
  input  logic              pol,
  input  logic [FILT_W-1:0] filt,
  input  logic [EDIV_W-1:0] ediv,
  output logic              ext_tick
);
  localparam int PW = (1 << EDIV_W) - 1;

  // Synchronizer
  logic [SYNC_N-1:0] sync_q;
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_N-2:0], pin};
  end

  logic level;
  assign level = sync_q[SYNC_N-1] ^ pol;

  // Glitch filter: level must differ for need_n samples in a row
  logic [FILT_W-1:0] need_n;
  logic [FILT_W-1:0] run_len;
  logic              filt_q;
  assign need_n = {1'b0, filt[FILT_W-1:1]} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q  <= 1'b0;
      run_len <= '0;
    end else if (level == filt_q) begin
      run_len <= '0;
    end else if ((run_len + 1'b1) >= need_n) begin
      filt_q  <= level;
      run_len <= '0;
    end else begin
      run_len <= run_len + 1'b1;
    end
  end

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (level == filt_q) |=> $stable(filt_q)); // R9

  // Rising edge detector
  logic filt_d, rise;
  always_ff @(posedge clk) begin
    if (rst) filt_d <= 1'b0;
    else     filt_d <= filt_q;
  end
  assign rise = filt_q & ~filt_d;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R6

  // Edge prescaler: pass one edge in 2**ediv
  logic [PW-1:0] pcnt, pmask;
  assign pmask = PW'((32'd1 << ediv) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) pcnt <= '0;
    else if (run && rise) pcnt <= (pcnt >= pmask) ? '0 : pcnt + 1'b1;
  end

  assign ext_tick = run && rise && (pcnt >= pmask);
endmodule

// File: rtl/ect_count_core.sv
module ect_count_core
  import ect_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TRIG_N = 3,
  parameter int TSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              mode_b,
  input  logic [2:0]        smode,
  input  logic [TSEL_W-1:0] tsel,
  input  logic [TRIG_N-1:0] int_trig,
  input  logic              ext_tick,
  input  logic [CNT_W-1:0]  div_val,
  input  logic [CNT_W-1:0]  period,
  input  logic              ovf_clr,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf
);
  localparam int NSRC = 1 << TSEL_W;

  logic [TRIG_N-1:0] trig_d, trig_rise;
  always_ff @(posedge clk) begin
    if (rst) trig_d <= '0;
    else     trig_d <= int_trig;
  end
  assign trig_rise = int_trig & ~trig_d;

  // Trigger selector: top code is the external path
  logic [NSRC-1:0] src_vec;
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == NSRC - 1) begin : g_ext
      assign src_vec[i] = ext_tick;
    end else if (i < TRIG_N) begin : g_int
      assign src_vec[i] = trig_rise[i];
    end else begin : g_none
      assign src_vec[i] = 1'b0;
    end
  end

  logic src;
  always_comb begin
    if (mode_b)                  src = ext_tick;
    else if (smode == SMODE_EXT) src = src_vec[tsel];
    else                         src = 1'b1;
  end

  // Count divider
  logic [CNT_W-1:0] dcnt;
  logic             tick, wrap;
  assign tick = run && src && (dcnt >= div_val);
  assign wrap = tick && (cnt == period);

  always_ff @(posedge clk) begin
    if (rst) dcnt <= '0;
    else if (run && src) dcnt <= tick ? '0 : dcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf <= 1'b0;
    else if (wrap)    ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt)); // R3
  AST_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt != period) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == period) |=> (cnt == '0) && ovf); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf); // R5
  AST_DIRECT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (mode_b && !ext_tick) |-> !tick); // R11
endmodule

// File: rtl/ext_clk_timer.sv
module ext_clk_timer
  import ect_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TRIG_N = 3,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              ext_pin,
  input  logic [TRIG_N-1:0] int_trig,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_flag
);
  ect_ctrl_t        ctrl;
  logic [CNT_W-1:0] div_val, period;
  logic             ovf_clr, ext_tick;

  ect_regs #(.DATA_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .div_val(div_val), .period(period), .ovf_clr(ovf_clr)
  );

  ect_ext_path #(.SYNC_N(SYNC_N), .FILT_W(4), .EDIV_W(2)) u_ext (
    .clk(clk), .rst(rst), .run(ctrl.run), .pin(ext_pin), .pol(ctrl.pol),
    .filt(ctrl.filt), .ediv(ctrl.ediv), .ext_tick(ext_tick)
  );

  ect_count_core #(.CNT_W(CNT_W), .TRIG_N(TRIG_N), .TSEL_W(2)) u_core (
    .clk(clk), .rst(rst), .run(ctrl.run), .mode_b(ctrl.mode_b),
    .smode(ctrl.smode), .tsel(ctrl.tsel), .int_trig(int_trig),
    .ext_tick(ext_tick), .div_val(div_val), .period(period),
    .ovf_clr(ovf_clr), .cnt(count), .ovf(ovf_flag)
  );
endmodule

// File: tb/tb_ext_clk_timer.sv
module tb_ext_clk_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ext_pin = 1'b0;
  logic [2:0]  int_trig = '0;
  logic [15:0] count;
  logic        ovf_flag;

  int checks = 0;
  int errors = 0;

  ext_clk_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_pin(ext_pin), .int_trig(int_trig), .count(count), .ovf_flag(ovf_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic [1:0]  ediv;
    logic        pol;
    logic [15:0] cdiv;
    logic [7:0]  edges;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 16'd0, 8'd5,  16'd5},  // R6 plain
    '{2'd1, 1'b0, 16'd0, 8'd8,  16'd4},  // R8 /2
    '{2'd2, 1'b0, 16'd0, 8'd8,  16'd2},  // R8 /4
    '{2'd3, 1'b0, 16'd0, 8'd16, 16'd2},  // R8 /8
    '{2'd3, 1'b0, 16'd0, 8'd7,  16'd0},  // R8 below threshold
    '{2'd0, 1'b1, 16'd0, 8'd6,  16'd6},  // R7 inverted
    '{2'd0, 1'b0, 16'd2, 8'd9,  16'd3},  // R12 divider 2
    '{2'd1, 1'b0, 16'd1, 8'd8,  16'd2}   // R12 with R8
  };

  function automatic logic [15:0] mk(logic run, logic mb, logic [2:0] sm,
                                     logic [1:0] ts, logic pol,
                                     logic [1:0] ed, logic [3:0] ft);
    return {2'b00, ft, ed, pol, ts, sm, mb, run};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(logic idle);
    @(negedge clk);
    ext_pin = idle; int_trig = '0; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int n, int hi, int lo, logic idle);
    for (int i = 0; i < n; i++) begin
      ext_pin = ~idle; wait_cyc(hi);
      ext_pin = idle;  wait_cyc(lo);
    end
  endtask

  task automatic trig_pulses(int idx, int n);
    for (int i = 0; i < n; i++) begin
      int_trig[idx] = 1'b1; wait_cyc(3);
      int_trig[idx] = 1'b0; wait_cyc(3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] c0;
    // R1 reset state
    do_reset(1'b0);
    check("R1 count", count, 0);
    check("R1 ovf", ovf_flag, 0);
    wait_cyc(5);
    check("R1 stopped", count, 0);

    // R2 free running on the clock
    wr(ect_pkg::A_PER, 16'hFFFF);
    wr(ect_pkg::A_CTRL, mk(1, 0, 3'd0, 2'd0, 0, 2'd0, 4'd0));
    c0 = count;
    wait_cyc(10);
    check("R2 step per clock", count, c0 + 16'd10);

    // R3 hold while stopped
    wr(ect_pkg::A_CTRL, mk(0, 0, 3'd0, 2'd0, 0, 2'd0, 4'd0));
    c0 = count;
    wait_cyc(10);
    check("R3 hold", count, c0);

    // R4 wrap at period
    do_reset(1'b0);
    wr(ect_pkg::A_PER, 16'h0032);
    wr(ect_pkg::A_CTRL, mk(1, 0, 3'd0, 2'd0, 0, 2'd0, 4'd0));
    for (int i = 0; i < 200 && count != 16'h0032; i++) @(negedge clk);
    check("R4 reached period", count, 16'h32);
    check("R4 no flag yet", ovf_flag, 0);
    @(negedge clk);
    check("R4 wrapped", count, 0);
    check("R4 flag set", ovf_flag, 1);

    // R5 sticky flag
    wr(ect_pkg::A_CTRL, mk(0, 0, 3'd0, 2'd0, 0, 2'd0, 4'd0));
    wait_cyc(5);
    check("R5 sticky", ovf_flag, 1);
    wr(ect_pkg::A_STAT, 16'h0001);
    check("R5 write one keeps", ovf_flag, 1);
    wr(ect_pkg::A_STAT, 16'h0000);
    check("R5 cleared", ovf_flag, 0);

    // R6 latency from pin to count
    do_reset(1'b0);
    wr(ect_pkg::A_PER, 16'hFFFF);
    wr(ect_pkg::A_CTRL, mk(1, 1, 3'd0, 2'd0, 0, 2'd0, 4'd0));
    wait_cyc(4);
    ext_pin = 1'b1;
    wait_cyc(3);
    check("R6 not yet", count, 0);
    wait_cyc(1);
    check("R6 third edge", count, 1);
    ext_pin = 1'b0;
    wait_cyc(8);

    // Vector table: R6 R7 R8 R12
    for (int v = 0; v < NV; v++) begin
      do_reset(VECS[v].pol);
      wr(ect_pkg::A_PER, 16'hFFFF);
      wr(ect_pkg::A_DIV, VECS[v].cdiv);
      wr(ect_pkg::A_CTRL, mk(1, 1, 3'd0, 2'd0, VECS[v].pol, VECS[v].ediv, 4'd0));
      pulses(int'(VECS[v].edges), 4, 4, VECS[v].pol);
      wait_cyc(8);
      check($sformatf("R8/R12 vector %0d", v), count, VECS[v].exp);
    end

    // R7 polarity at the edge level
    do_reset(1'b0);
    wr(ect_pkg::A_PER, 16'hFFFF);
    wr(ect_pkg::A_CTRL, mk(1, 1, 3'd0, 2'd0, 0, 2'd0, 4'd0));
    ext_pin = 1'b1; wait_cyc(8);
    ext_pin = 1'b0; wait_cyc(8);
    check("R7 rising only", count, 1);
    do_reset(1'b1);
    wr(ect_pkg::A_PER, 16'hFFFF);
    wr(ect_pkg::A_CTRL, mk(1, 1, 3'd0, 2'd0, 1, 2'd0, 4'd0));
    wait_cyc(6);
    ext_pin = 1'b0; wait_cyc(8);
    check("R7 falling counts", count, 1);
    ext_pin = 1'b1; wait_cyc(8);
    check("R7 rising ignored", count, 1);

    // R9 filter boundaries
    do_reset(1'b0);
    wr(ect_pkg::A_PER, 16'hFFFF);
    wr(ect_pkg::A_CTRL, mk(1, 1, 3'd0, 2'd0, 0, 2'd0, 4'hF));
    wait_cyc(12);
    pulses(1, 7, 12, 1'b0);
    check("R9 F=15 short pulse", count, 0);
    pulses(1, 8, 12, 1'b0);
    check("R9 F=15 exact pulse", count, 1);
    do_reset(1'b0);
    wr(ect_pkg::A_PER, 16'hFFFF);
    wr(ect_pkg::A_CTRL, mk(1, 1, 3'd0, 2'd0, 0, 2'd0, 4'h6));
    wait_cyc(8);
    pulses(1, 3, 8, 1'b0);
    check("R9 F=6 short pulse", count, 0);
    pulses(1, 4, 8, 1'b0);
    check("R9 F=6 exact pulse", count, 1);

    // R10 slave mode trigger select
    do_reset(1'b0);
    wr(ect_pkg::A_PER, 16'hFFFF);
    wr(ect_pkg::A_CTRL, mk(1, 0, 3'b111, 2'd3, 0, 2'd0, 4'd0));
    pulses(3, 4, 4, 1'b0);
    wait_cyc(6);
    check("R10 pin via selector", count, 3);
    wr(ect_pkg::A_CTRL, mk(1, 0, 3'b111, 2'd1, 0, 2'd0, 4'd0));
    c0 = count;
    pulses(2, 4, 4, 1'b0);
    wait_cyc(6);
    check("R10 pin ignored", count, c0);
    trig_pulses(1, 4);
    check("R10 trigger line 1", count, c0 + 16'd4);
    trig_pulses(0, 2);
    check("R10 other line ignored", count, c0 + 16'd4);

    // R11 direct enable wins
    do_reset(1'b0);
    wr(ect_pkg::A_PER, 16'hFFFF);
    wr(ect_pkg::A_CTRL, mk(1, 1, 3'b111, 2'd0, 0, 2'd0, 4'd0));
    trig_pulses(0, 3);
    check("R11 trigger ignored", count, 0);
    pulses(2, 4, 4, 1'b0);
    wait_cyc(6);
    check("R11 pin counts", count, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule